// File: doc/BRIEF.md
# Interleaved complex sample port

This block sits between a streaming transform core and the circuit around it. Outside the chip boundary, complex samples travel on one 18-bit two's-complement bus in each direction. The real half and the imaginary half of a sample take turns on the bus, one half per edge of a clock that runs at twice the core rate. Inside, the core works on whole complex samples, one per core-clock cycle.

On the receive side the block collects the two halves of each incoming sample. It hands the pair to the core as parallel real and imaginary words, together with a frame-start flag. On the transmit side it takes one parallel complex result per core cycle from the core and puts its halves back onto the output bus, with an output frame marker that spans the whole first sample of a frame.

Both clocks come from one source and rise together, so every other double-rate edge coincides with a core rising edge. The block finds the half on each double-rate edge from a toggle register in the core domain and does not sample the core clock as data. Reset must be released during the low half of the core clock. The first double-rate edge after release is then a core rising edge.

Top module: `iq_port`

## Requirements
- R1: While reset is asserted and until the first clock edge after its release, rx_re, rx_im, rx_sof, ser_out and ser_out_sof are all zero.
- R2: A double-rate rising edge that coincides with a core rising edge (the core-clock-high half) takes ser_in as the real part of a sample. The next double-rate edge (the core-clock-low half) takes ser_in as its imaginary part, and the two kinds of edge strictly alternate.
- R3: A sample whose imaginary half is captured on a low-half edge appears on rx_re and rx_im from the next core rising edge, and holds there for exactly one core cycle.
- R4: rx_sof is presented with a sample and equals ser_in_sof as sampled on that sample's real-half edge.
- R5: ser_in_sof is ignored on low-half edges. A marker raised only during the imaginary half leaves rx_sof at 0 for that sample.
- R6: Let a result be applied on tx_re and tx_im before core rising edge k. ser_out carries its real part from core edge k+1 for the high half, and its imaginary part for the low half that follows.
- R7: ser_out_sof is high during both halves of an output sample whose tx_sof was 1, and low during both halves of every other sample.
- R8: Values pass bit-exact in both directions, including the most negative code 0x20000 and the most positive code 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_core | input | 1 | Core clock, one complex sample per cycle |
| clk_dbl | input | 1 | Double-rate clock, rising edges aligned with core rising edges |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| ser_in | input | 18 | Interleaved input bus, real then imaginary, two's complement |
| ser_in_sof | input | 1 | Input frame marker, meaningful on the real half |
| tx_re | input | 18 | Real part of the core result |
| tx_im | input | 18 | Imaginary part of the core result |
| tx_sof | input | 1 | Frame start of the core result |
| rx_re | output | 18 | Real part of the received sample |
| rx_im | output | 18 | Imaginary part of the received sample |
| rx_sof | output | 1 | Frame start of the received sample |
| ser_out | output | 18 | Interleaved output bus, real then imaginary |
| ser_out_sof | output | 1 | Output frame marker, high over both halves of the first sample |

## Verification
The bench builds the block with the default 18-bit word, so the extreme codes 0x20000 and 0x1FFFF reach the sign bit and the top magnitude bit in both directions. A behavioural model works out from the core-clock level at each falling double-rate edge which half comes next. It predicts every received pair and every serialized half one or two cycles ahead. Input markers are placed on real halves and, as decoys, on imaginary halves, and output markers fall at other offsets within the frame. This way a marker taken in the wrong half or held for only one half shows up as a mismatch.

// File: rtl/iq_port_pkg.sv
package iq_port_pkg;

    parameter int IQ_W = 18;

    typedef enum logic {
        HALF_IM = 1'b0,
        HALF_RE = 1'b1
    } half_e;

endpackage

// File: rtl/iq_half_tracker.sv
module iq_half_tracker
    import iq_port_pkg::*;
(
    input  logic  clk_core,
    input  logic  clk_dbl,
    input  logic  rst_n,
    output half_e half_o
);

    typedef struct packed {
        logic tog;
    } core_st_t;

    typedef struct packed {
        logic seen;
    } dbl_st_t;

    core_st_t core_d, core_q;
    dbl_st_t  dbl_d, dbl_q;

    // core domain: flips once per core cycle
    always_comb begin
        core_d     = core_q;
        core_d.tog = ~core_q.tog;
    end

    always_ff @(posedge clk_core or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    // double-rate domain: remembers the toggle seen on the previous edge
    always_comb begin
        dbl_d      = dbl_q;
        dbl_d.seen = core_q.tog;
    end

    always_ff @(posedge clk_dbl or negedge rst_n) begin
        if (!rst_n) dbl_q <= '0;
        else        dbl_q <= dbl_d;
    end

    // equal: this edge coincides with a core rising edge (high half)
    assign half_o = (core_q.tog == dbl_q.seen) ? HALF_RE : HALF_IM;

    AST_HALF_RE_THEN_IM: assert property (@(posedge clk_dbl) disable iff (!rst_n)
        (half_o == HALF_RE) |=> (half_o == HALF_IM)); // R2
    AST_HALF_IM_THEN_RE: assert property (@(posedge clk_dbl) disable iff (!rst_n)
        (half_o == HALF_IM) |=> (half_o == HALF_RE)); // R2

endmodule

// File: rtl/iq_rx_split.sv
module iq_rx_split
    import iq_port_pkg::*;
#(
    parameter int W = IQ_W
) (
    input  logic         clk_dbl,
    input  logic         rst_n,
    input  half_e        half_i,
    input  logic [W-1:0] din,
    input  logic         din_sof,
    output logic [W-1:0] pair_re,
    output logic [W-1:0] pair_im,
    output logic         pair_sof
);

    typedef struct packed {
        logic [W-1:0] re_hold;
        logic         sof_hold;
        logic [W-1:0] p_re;
        logic [W-1:0] p_im;
        logic         p_sof;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (half_i == HALF_RE) begin
            st_d.re_hold  = din;
            st_d.sof_hold = din_sof;
        end else begin
            st_d.p_re  = st_q.re_hold;
            st_d.p_im  = din;
            st_d.p_sof = st_q.sof_hold;
        end
    end

    always_ff @(posedge clk_dbl or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pair_re  = st_q.p_re;
    assign pair_im  = st_q.p_im;
    assign pair_sof = st_q.p_sof;

    AST_PAIR_STEADY_ON_RE: assert property (@(posedge clk_dbl) disable iff (!rst_n)
        (half_i == HALF_RE) |=> ($stable(pair_re) && $stable(pair_im) && $stable(pair_sof))); // R3
    AST_MARK_IGNORED_ON_IM: assert property (@(posedge clk_dbl) disable iff (!rst_n)
        (half_i == HALF_IM) |=> $stable(st_q.sof_hold)); // R5

endmodule

// File: rtl/iq_core_reg.sv
module iq_core_reg
    import iq_port_pkg::*;
#(
    parameter int W = IQ_W
) (
    input  logic         clk_core,
    input  logic         rst_n,
    input  logic [W-1:0] d_re,
    input  logic [W-1:0] d_im,
    input  logic         d_sof,
    output logic [W-1:0] q_re,
    output logic [W-1:0] q_im,
    output logic         q_sof
);

    typedef struct packed {
        logic [W-1:0] re;
        logic [W-1:0] im;
        logic         sof;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.re  = d_re;
        st_d.im  = d_im;
        st_d.sof = d_sof;
    end

    always_ff @(posedge clk_core or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_re  = st_q.re;
    assign q_im  = st_q.im;
    assign q_sof = st_q.sof;

endmodule

// File: rtl/iq_tx_merge.sv
module iq_tx_merge
    import iq_port_pkg::*;
#(
    parameter int W = IQ_W
) (
    input  logic         clk_dbl,
    input  logic         rst_n,
    input  half_e        half_i,
    input  logic [W-1:0] s_re,
    input  logic [W-1:0] s_im,
    input  logic         s_sof,
    output logic [W-1:0] dout,
    output logic         dout_sof
);

    typedef struct packed {
        logic [W-1:0] im_hold;
        logic [W-1:0] bus;
        logic         mark;
    } st_t;

    st_t st_d, st_q;

    // the imaginary half is stashed on the high half, because the core
    // register moves on to the next result at that same edge
    always_comb begin
        st_d = st_q;
        if (half_i == HALF_RE) begin
            st_d.bus     = s_re;
            st_d.im_hold = s_im;
            st_d.mark    = s_sof;
        end else begin
            st_d.bus = st_q.im_hold;
        end
    end

    always_ff @(posedge clk_dbl or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout     = st_q.bus;
    assign dout_sof = st_q.mark;

    AST_MARK_SPANS_SAMPLE: assert property (@(posedge clk_dbl) disable iff (!rst_n)
        (half_i == HALF_IM) |=> $stable(dout_sof)); // R7

endmodule

// File: rtl/iq_port.sv
module iq_port
    import iq_port_pkg::*;
#(
    parameter int W = IQ_W
) (
    input  logic         clk_core,
    input  logic         clk_dbl,
    input  logic         rst_n,
    input  logic [W-1:0] ser_in,
    input  logic         ser_in_sof,
    input  logic [W-1:0] tx_re,
    input  logic [W-1:0] tx_im,
    input  logic         tx_sof,
    output logic [W-1:0] rx_re,
    output logic [W-1:0] rx_im,
    output logic         rx_sof,
    output logic [W-1:0] ser_out,
    output logic         ser_out_sof
);

    half_e        half;
    logic [W-1:0] pr_re, pr_im;
    logic         pr_sof;
    logic [W-1:0] th_re, th_im;
    logic         th_sof;

    iq_half_tracker u_half (
        .clk_core (clk_core),
        .clk_dbl  (clk_dbl),
        .rst_n    (rst_n),
        .half_o   (half)
    );

    iq_rx_split #(.W(W)) u_split (
        .clk_dbl  (clk_dbl),
        .rst_n    (rst_n),
        .half_i   (half),
        .din      (ser_in),
        .din_sof  (ser_in_sof),
        .pair_re  (pr_re),
        .pair_im  (pr_im),
        .pair_sof (pr_sof)
    );

    iq_core_reg #(.W(W)) u_rx_reg (
        .clk_core (clk_core),
        .rst_n    (rst_n),
        .d_re     (pr_re),
        .d_im     (pr_im),
        .d_sof    (pr_sof),
        .q_re     (rx_re),
        .q_im     (rx_im),
        .q_sof    (rx_sof)
    );

    iq_core_reg #(.W(W)) u_tx_reg (
        .clk_core (clk_core),
        .rst_n    (rst_n),
        .d_re     (tx_re),
        .d_im     (tx_im),
        .d_sof    (tx_sof),
        .q_re     (th_re),
        .q_im     (th_im),
        .q_sof    (th_sof)
    );

    iq_tx_merge #(.W(W)) u_merge (
        .clk_dbl  (clk_dbl),
        .rst_n    (rst_n),
        .half_i   (half),
        .s_re     (th_re),
        .s_im     (th_im),
        .s_sof    (th_sof),
        .dout     (ser_out),
        .dout_sof (ser_out_sof)
    );

endmodule

// File: tb/sim_iq_port.sv
`timescale 1ns/1ps
module sim_iq_port;

    localparam int W = 18;

    typedef struct {
        logic [W-1:0] re;
        logic [W-1:0] im;
        logic         m_re;
        logic         m_im;
        logic         big;
    } smp_t;

    logic         clk_core = 1'b0, clk_dbl = 1'b0, rst_n = 1'b0;
    logic [W-1:0] ser_in = '0, tx_re = '0, tx_im = '0;
    logic         ser_in_sof = 1'b0, tx_sof = 1'b0;
    logic [W-1:0] rx_re, rx_im, ser_out;
    logic         rx_sof, ser_out_sof;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    iq_port #(.W(W)) u0 (
        .clk_core(clk_core), .clk_dbl(clk_dbl), .rst_n(rst_n),
        .ser_in(ser_in), .ser_in_sof(ser_in_sof),
        .tx_re(tx_re), .tx_im(tx_im), .tx_sof(tx_sof),
        .rx_re(rx_re), .rx_im(rx_im), .rx_sof(rx_sof),
        .ser_out(ser_out), .ser_out_sof(ser_out_sof)
    );

    // one source: 50 MHz double-rate clock, core clock flips on its rising edges
    always begin
        #10 clk_dbl = 1'b1; clk_core = ~clk_core;
        #10 clk_dbl = 1'b0;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic smp_t mk(input int j);
        smp_t s;
        s.re   = W'($urandom);
        s.im   = W'($urandom);
        s.big  = 1'b0;
        if (j % 8 == 2) begin s.re = W'(j); s.im = W'(-j); end
        if (j % 11 == 5) begin s.re = 18'h20000; s.im = 18'h1FFFF; s.big = 1'b1; end
        if (j % 13 == 6) begin s.re = 18'h1FFFF; s.im = 18'h20000; s.big = 1'b1; end
        s.m_re = (j % 16 == 0);
        s.m_im = (j % 16 == 7);
        return s;
    endfunction

    initial begin
        smp_t cur, prev, h1, h2, t;
        int j, k;
        cur  = '{re: '0, im: '0, m_re: 0, m_im: 0, big: 0};
        prev = cur; h1 = cur; h2 = cur;
        j = 0; k = 0;
        #60;
        chk("R1 rx_re", int'(rx_re), 0);
        chk("R1 rx_im", int'(rx_im), 0);
        chk("R1 rx_sof", int'(rx_sof), 0);
        chk("R1 ser_out", int'(ser_out), 0);
        chk("R1 ser_out_sof", int'(ser_out_sof), 0);
        #25 rst_n = 1'b1;
        repeat (800) begin
            @(negedge clk_dbl);
            if (clk_core) begin
                // next edge is a low half; rx holds sample prev
                chk(prev.big ? "R8 rx_re" : "R2 rx_re", int'(rx_re), int'(prev.re));
                chk(prev.big ? "R8 rx_im" : "R3 rx_im", int'(rx_im), int'(prev.im));
                chk(prev.m_im && !prev.m_re ? "R5 rx_sof" : "R4 rx_sof",
                    int'(rx_sof), int'(prev.m_re));
                chk(h2.big ? "R8 ser_out re" : "R6 ser_out re", int'(ser_out), int'(h2.re));
                chk("R7 ser_out_sof re half", int'(ser_out_sof), int'(h2.m_re));
                ser_in     = cur.im;
                ser_in_sof = cur.m_im;
                prev = cur;
            end else begin
                // next edge is a high half
                chk(h2.big ? "R8 ser_out im" : "R6 ser_out im", int'(ser_out), int'(h2.im));
                chk("R7 ser_out_sof im half", int'(ser_out_sof), int'(h2.m_re));
                cur = mk(j); j++;
                ser_in     = cur.re;
                ser_in_sof = cur.m_re;
                t = mk(k + 3); k++;
                t.m_re = (k % 16 == 3);
                tx_re  = t.re;
                tx_im  = t.im;
                tx_sof = t.m_re;
                h2 = h1; h1 = t;
            end
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule